// File: doc/BRIEF.md
# Page-Walk Directory Cache with Store Snooping

This block is the small internal cache that sits beside a hardware page walker. It keeps copies of upper-level directory entries from a four-level page table. Each copy is indexed by its table level and by the virtual-address bits that select it, and it carries the physical address of the 64-byte line it was read from. When a walk starts, the walker presents the virtual address. The cache answers in the same cycle with the deepest directory level it holds for that address, together with the physical base of the next table down. The walker can then skip every level above it. Leaf translations are never installed here.

Page tables live in ordinary memory, so a store can rewrite a directory entry the cache already holds. Every committed store address is compared at line granularity against the source lines of all live entries, and each match is discarded. A snoop hit also masks any lookup in the same cycle. Software keeps two explicit controls. Writing a new page-table root empties the whole cache. A single-address invalidate removes every entry on that address's walk path.

Each of the eight slots is a two-state machine with states `ENT_EMPTY` and `ENT_LIVE`. The transitions are:
- **install**: `ENT_EMPTY` to `ENT_LIVE` on an accepted fill aimed at the slot.
- **reload**: `ENT_LIVE` to `ENT_LIVE` when an accepted fill overwrites the slot.
- **flush**: `ENT_LIVE` to `ENT_EMPTY` on a root write.
- **snoop kill**: `ENT_LIVE` to `ENT_EMPTY` when a store hits the slot's source line.
- **address kill**: `ENT_LIVE` to `ENT_EMPTY` when an invalidate address falls under the slot's prefix.

A fill goes to an existing slot that already holds the same level and prefix. Otherwise it goes to the slot under a round-robin pointer.

Top module: `pwc_dir_cache`

## Requirements
- R1: After reset every slot is empty, and every lookup reports a miss.
- R2: After a fill is accepted at a clock edge, a lookup in any later cycle whose address matches the fill's prefix returns hit, the fill's level (2, 3 or 4) and its next-table base. The lookup result is combinational.
- R3: An entry of level L compares virtual-address bits [47 : 12+9*(L-1)] only. So level 4 uses bits 47..39, level 3 uses bits 47..30 and level 2 uses bits 47..21. Addresses that differ only below that boundary hit the entry; addresses that differ above it miss.
- R4: When entries at several levels match one address, the lookup returns the one with the lowest level number. A level-2 match beats a level-3 match, which beats a level-4 match.
- R5: A store snoop invalidates, at the clock edge, every live entry whose source physical address has the same bits [39:6] (the same 64-byte line) as the store. A store to any other line changes nothing.
- R6: In a cycle with a snoop, a lookup never returns an entry whose source line matches the snooped line. It reports the next shallower match instead, or a miss.
- R7: A fill whose source line matches a snoop in the same cycle is dropped. A fill whose source line differs from that snoop is installed.
- R8: A root write empties every slot at the clock edge, and a fill presented in the same cycle is dropped.
- R9: A single-address invalidate removes every entry whose prefix matches that address at the entry's own level. Entries with any other prefix stay.
- R10: New fills replace slots in round-robin order. Filling nine distinct prefixes in a row evicts the first one and keeps the other eight.
- R11: A fill with the same level and prefix as a live entry overwrites that entry in place. It does not advance the replacement pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a cached directory entry |
| lk_level | output | 3 | Level of the returned entry (2..4) |
| lk_base | output | 40 | Physical base of the next table down |
| fl_valid | input | 1 | Fill request from the walker |
| fl_level | input | 3 | Level of the filled entry (2..4) |
| fl_va | input | 48 | Virtual address whose prefix indexes the fill |
| fl_base | input | 40 | Next-table physical base carried by the entry |
| fl_src | input | 40 | Physical address the entry was read from |
| sn_valid | input | 1 | Committed store snoop |
| sn_addr | input | 40 | Store physical address |
| root_wr | input | 1 | New page-table root written: flush all |
| inv_valid | input | 1 | Single-address invalidate |
| inv_va | input | 48 | Virtual address to invalidate |

## Verification
The assertions rely on three input rules. The walker presents fill levels only in the range 2 to 4. It issues a fill only after a lookup for that prefix and level has missed. Reset is held for at least one clock edge. Inside those rules, the assertions check three things: a snoop hit is never returned, a root write or a snoop kill leaves the affected slots empty, and the replacement pointer moves only when a new slot is taken. The directed tasks keep every fill level in range, and they present addresses that share or differ in exactly the bit fields under test. The same-cycle races (snoop against lookup, snoop against fill, root write against fill) are driven in one cycle and checked on both sides of the edge.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    parameter int VA_W    = 48;
    parameter int PA_W    = 40;
    parameter int LINE_SH = 6;
    parameter int PG_SH   = 12;
    parameter int IDX_W   = 9;
    parameter int LVL_MIN = 2;
    parameter int LVL_MAX = 4;
    parameter int LVL_W   = 3;

    localparam int TAG_LO = PG_SH + IDX_W * (LVL_MIN - 1);
    localparam int TAG_W  = VA_W - TAG_LO;
    localparam int LINE_W = PA_W - LINE_SH;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [PA_W-1:0]   pa_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {ENT_EMPTY, ENT_LIVE} ent_st_e;

    typedef struct packed {
        lvl_t  lvl;
        tag_t  tag;
        pa_t   base;
        line_t src;
    } ent_t;

    // Bits of the tag that take part in the compare for an entry of level l.
    function automatic tag_t lvl_mask(lvl_t l);
        tag_t m;
        m = '1;
        for (int i = 0; i < TAG_W; i++) begin
            if (i < IDX_W * (int'(l) - LVL_MIN)) m[i] = 1'b0;
        end
        return m;
    endfunction

    function automatic logic tag_eq(tag_t a, tag_t b, lvl_t l);
        return ((a ^ b) & lvl_mask(l)) == '0;
    endfunction
endpackage

// File: rtl/pwc_entry.sv
module pwc_entry
    import pwc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush_all,
    input  logic  fill_we,
    input  ent_t  fill_d,
    input  logic  sn_valid,
    input  line_t sn_line,
    input  logic  inv_valid,
    input  tag_t  inv_tag,
    input  tag_t  lk_tag,
    input  tag_t  fl_tag,
    input  lvl_t  fl_lvl,
    output logic  live,
    output logic  lk_match,
    output logic  dup_match,
    output ent_t  q
);
    ent_st_e st, st_nxt;
    logic snp_hit, inv_hit;

    assign live    = (st == ENT_LIVE);
    assign snp_hit = live && sn_valid && (q.src == sn_line);
    assign inv_hit = live && inv_valid && tag_eq(q.tag, inv_tag, q.lvl);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ENT_EMPTY: if (fill_we && !flush_all) st_nxt = ENT_LIVE;      // install
            ENT_LIVE: begin
                if (flush_all)               st_nxt = ENT_EMPTY;          // flush
                else if (fill_we)            st_nxt = ENT_LIVE;           // reload
                else if (snp_hit || inv_hit) st_nxt = ENT_EMPTY;          // snoop / address kill
            end
            default: st_nxt = ENT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ENT_EMPTY;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (fill_we) q <= fill_d;
    end

    always_comb begin
        lk_match  = live && !snp_hit && tag_eq(q.tag, lk_tag, q.lvl);
        dup_match = live && (q.lvl == fl_lvl) && tag_eq(q.tag, fl_tag, q.lvl);
    end

    a_r5_snoop_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && !fill_we) |=> (st == ENT_EMPTY));
    a_r8_flush_slot: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (st == ENT_EMPTY));
endmodule

// File: rtl/pwc_rr.sv
module pwc_rr #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [N-1:0] victim
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;
    logic [PW-1:0] ptr;

    always_ff @(posedge clk) begin
        if (!rst_n)                      ptr <= '0;
        else if (adv && ptr == PW'(N-1)) ptr <= '0;
        else if (adv)                    ptr <= ptr + 1'b1;
    end

    always_comb begin
        victim = '0;
        victim[ptr] = 1'b1;
    end

    a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr));
    a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(N-1));
endmodule

// File: rtl/pwc_pick.sv
module pwc_pick
    import pwc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] match,
    input  ent_t         ents [N],
    output logic         hit,
    output ent_t         sel
);
    // Deepest level (smallest number) wins; lowest slot breaks a tie.
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i] && (!hit || ents[i].lvl < sel.lvl)) begin
                hit = 1'b1;
                sel = ents[i];
            end
        end
    end
endmodule

// File: rtl/pwc_dir_cache.sv
module pwc_dir_cache
    import pwc_pkg::*;
#(
    parameter int N_ENT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_va,
    output logic            lk_hit,
    output logic [LVL_W-1:0] lk_level,
    output logic [PA_W-1:0] lk_base,
    input  logic            fl_valid,
    input  logic [LVL_W-1:0] fl_level,
    input  logic [VA_W-1:0] fl_va,
    input  logic [PA_W-1:0] fl_base,
    input  logic [PA_W-1:0] fl_src,
    input  logic            sn_valid,
    input  logic [PA_W-1:0] sn_addr,
    input  logic            root_wr,
    input  logic            inv_valid,
    input  logic [VA_W-1:0] inv_va
);
    tag_t  lk_tag, fl_tag, inv_tag;
    line_t sn_line, fl_line;
    logic  fill_ok, any_dup;
    logic [N_ENT-1:0] live_v, lk_m, dup_v, dup_first, victim, fill_we;
    ent_t  ents [N_ENT];
    ent_t  fill_d, sel;
    logic  pick_hit;

    assign lk_tag  = lk_va[VA_W-1:TAG_LO];
    assign fl_tag  = fl_va[VA_W-1:TAG_LO];
    assign inv_tag = inv_va[VA_W-1:TAG_LO];
    assign sn_line = sn_addr[PA_W-1:LINE_SH];
    assign fl_line = fl_src[PA_W-1:LINE_SH];
    assign fill_d  = '{lvl: fl_level, tag: fl_tag, base: fl_base, src: fl_line};

    // A fill loses to a flush, to a snoop of its own source line, and to an
    // invalidate that covers its prefix.
    assign fill_ok = fl_valid && !root_wr
                  && !(sn_valid && fl_line == sn_line)
                  && !(inv_valid && tag_eq(fl_tag, inv_tag, fl_level));

    always_comb begin
        dup_first = '0;
        any_dup   = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (dup_v[i] && !any_dup) begin
                dup_first[i] = 1'b1;
                any_dup      = 1'b1;
            end
        end
        fill_we = fill_ok ? (any_dup ? dup_first : victim) : '0;
    end

    pwc_rr #(.N(N_ENT)) u_rr (
        .clk(clk), .rst_n(rst_n), .adv(fill_ok && !any_dup), .victim(victim)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        pwc_entry u_ent (
            .clk(clk), .rst_n(rst_n), .flush_all(root_wr),
            .fill_we(fill_we[g]), .fill_d(fill_d),
            .sn_valid(sn_valid), .sn_line(sn_line),
            .inv_valid(inv_valid), .inv_tag(inv_tag),
            .lk_tag(lk_tag), .fl_tag(fl_tag), .fl_lvl(fl_level),
            .live(live_v[g]), .lk_match(lk_m[g]), .dup_match(dup_v[g]),
            .q(ents[g])
        );
    end

    pwc_pick #(.N(N_ENT)) u_pick (
        .match(lk_valid ? lk_m : '0), .ents(ents), .hit(pick_hit), .sel(sel)
    );

    assign lk_hit   = lk_valid && pick_hit;
    assign lk_level = sel.lvl;
    assign lk_base  = sel.base;

    logic unused_bits;
    assign unused_bits = ^{lk_va[TAG_LO-1:0], fl_va[TAG_LO-1:0], inv_va[TAG_LO-1:0],
                           sn_addr[LINE_SH-1:0], fl_src[LINE_SH-1:0], sel.tag};

    a_r6_snoop_masks_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && sn_valid) |-> (sel.src != sn_line));
    a_r2_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_level >= LVL_W'(LVL_MIN) && lk_level <= LVL_W'(LVL_MAX)));
    a_r8_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        root_wr |=> (live_v == '0));
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (live_v == '0));
endmodule

// File: tb/sim_pwc_dir_cache.sv
module sim_pwc_dir_cache;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_valid = 1'b1, fl_valid = 1'b0, sn_valid = 1'b0;
    logic        root_wr = 1'b0, inv_valid = 1'b0;
    logic [47:0] lk_va = '0, fl_va = '0, inv_va = '0;
    logic [2:0]  fl_level = 3'd4, lk_level;
    logic [39:0] fl_base = '0, fl_src = '0, sn_addr = '0, lk_base;
    logic        lk_hit;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwc_dir_cache u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_level(lk_level), .lk_base(lk_base),
        .fl_valid(fl_valid), .fl_level(fl_level), .fl_va(fl_va),
        .fl_base(fl_base), .fl_src(fl_src), .sn_valid(sn_valid),
        .sn_addr(sn_addr), .root_wr(root_wr), .inv_valid(inv_valid), .inv_va(inv_va)
    );

    function automatic logic [47:0] va_of(logic [8:0] a, logic [8:0] b, logic [8:0] c);
        return {a, b, c, 21'h0};
    endfunction

    task automatic look(string req, logic [47:0] va, logic eh, logic [2:0] el, logic [39:0] eb);
        lk_va = va;
        #2;
        checks++;
        if (lk_hit !== eh || (eh && (lk_level !== el || lk_base !== eb))) begin
            fails++;
            $display("FAIL %s va=%h actual hit=%b lvl=%0d base=%h expected hit=%b lvl=%0d base=%h",
                     req, va, lk_hit, lk_level, lk_base, eh, el, eb);
        end
    endtask

    // Drives one fill for one clock edge, with optional same-cycle snoop / root.
    task automatic fill(logic [2:0] l, logic [47:0] va, logic [39:0] b, logic [39:0] s,
                        logic snp, logic [39:0] sa, logic rt);
        fl_level = l; fl_va = va; fl_base = b; fl_src = s; fl_valid = 1'b1;
        sn_valid = snp; sn_addr = sa; root_wr = rt;
        @(posedge clk); #1;
        fl_valid = 1'b0; sn_valid = 1'b0; root_wr = 1'b0;
    endtask

    task automatic snoop(logic [39:0] sa);
        sn_valid = 1'b1; sn_addr = sa;
        @(posedge clk); #1;
        sn_valid = 1'b0;
    endtask

    task automatic t_reset;
        look("R1", va_of(1, 1, 1), 0, 0, 0);
        look("R1", va_of(0, 0, 0), 0, 0, 0);
    endtask

    task automatic t_levels;
        fill(4, va_of(1, 0, 0), 40'h44_0000_0000, 40'h1000, 0, 0, 0);
        look("R2", va_of(1, 5, 7), 1, 4, 40'h44_0000_0000);
        look("R3", va_of(2, 5, 7), 0, 0, 0);
        fill(3, va_of(1, 2, 0), 40'h33_0000_0000, 40'h1008, 0, 0, 0);
        fill(2, va_of(1, 2, 3), 40'h22_0000_0000, 40'h2000, 0, 0, 0);
        look("R4", va_of(1, 2, 3), 1, 2, 40'h22_0000_0000);
        look("R4", va_of(1, 2, 4), 1, 3, 40'h33_0000_0000);
        look("R3", va_of(1, 3, 3), 1, 4, 40'h44_0000_0000);
        look("R3", va_of(1, 2, 3) | 48'h1F_FFFF, 1, 2, 40'h22_0000_0000);
    endtask

    task automatic t_snoop_vs_lookup;
        sn_valid = 1'b1; sn_addr = 40'h2010;
        look("R6", va_of(1, 2, 3), 1, 3, 40'h33_0000_0000);
        @(posedge clk); #1;
        sn_valid = 1'b0;
        look("R5", va_of(1, 2, 3), 1, 3, 40'h33_0000_0000);
    endtask

    task automatic t_snoop_lines;
        snoop(40'h1040);
        look("R5", va_of(1, 2, 4), 1, 3, 40'h33_0000_0000);
        snoop(40'h1030);
        look("R5", va_of(1, 2, 4), 0, 0, 0);
        look("R5", va_of(1, 7, 7), 0, 0, 0);
    endtask

    task automatic t_fill_race;
        fill(4, va_of(3, 0, 0), 40'h55_0000_0000, 40'h3000, 1, 40'h3020, 0);
        look("R7", va_of(3, 0, 0), 0, 0, 0);
        fill(4, va_of(3, 0, 0), 40'h55_0000_0000, 40'h3000, 1, 40'h5000, 0);
        look("R7", va_of(3, 0, 0), 1, 4, 40'h55_0000_0000);
    endtask

    task automatic t_addr_inv;
        fill(3, va_of(3, 1, 0), 40'h66_0000_0000, 40'h3100, 0, 0, 0);
        fill(2, va_of(4, 1, 1), 40'h77_0000_0000, 40'h3200, 0, 0, 0);
        inv_valid = 1'b1; inv_va = va_of(3, 1, 9);
        @(posedge clk); #1;
        inv_valid = 1'b0;
        look("R9", va_of(3, 1, 0), 0, 0, 0);
        look("R9", va_of(3, 4, 0), 0, 0, 0);
        look("R9", va_of(4, 1, 1), 1, 2, 40'h77_0000_0000);
    endtask

    task automatic t_root;
        fill(4, va_of(6, 0, 0), 40'h88_0000_0000, 40'h6000, 0, 0, 1);
        look("R8", va_of(4, 1, 1), 0, 0, 0);
        look("R8", va_of(6, 0, 0), 0, 0, 0);
    endtask

    task automatic t_round_robin;
        for (int k = 0; k < 9; k++)
            fill(4, va_of(9'(10 + k), 0, 0), 40'(k), 40'(32'h8000 + 64 * k), 0, 0, 0);
        look("R10", va_of(10, 0, 0), 0, 0, 0);
        look("R10", va_of(11, 0, 0), 1, 4, 40'd1);
        look("R10", va_of(18, 0, 0), 1, 4, 40'd8);
    endtask

    task automatic t_refill;
        fill(4, va_of(12, 0, 0), 40'h777, 40'h9000, 0, 0, 0);
        fill(4, va_of(30, 0, 0), 40'h30, 40'h9100, 0, 0, 0);
        look("R11", va_of(12, 0, 0), 1, 4, 40'h777);
        look("R11", va_of(11, 0, 0), 0, 0, 0);
        look("R11", va_of(13, 0, 0), 1, 4, 40'd3);
        look("R11", va_of(30, 0, 0), 1, 4, 40'h30);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_levels();
        t_snoop_vs_lookup();
        t_snoop_lines();
        t_fill_race();
        t_addr_inv();
        t_root();
        t_round_robin();
        t_refill();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule